// File: doc/BRIEF.md
# Receive Address Filter Engine

This block decides, for each received frame, whether the frame is kept or dropped, looking only at the 48-bit destination address. The receive datapath presents the address with a one-cycle strobe once the address has been assembled. Two clocks later the block returns an accept or reject verdict. With the verdict it reports which rule produced it: an exact-match entry, the multicast hash, promiscuous mode, or no rule at all.

The filter holds three kinds of rule, all configured through a simple 16-bit register write port.

- **Exact-match entries.** There are several of them. Each holds a stored 48-bit address and has its own enable bit.
- **Multicast hash table.** It has 64 bins. A bin is chosen by six bits of a CRC-32 taken over the six address bytes. The block computes that CRC itself, over the address only and not over the frame.
- **Promiscuous switch.** When on, it accepts everything.

Loading entry 0 with all ones and enabling it turns that entry into the broadcast acceptor. Writing 0xFFFF into every hash word accepts every multicast address.

Top module: `rxaf_top`

## Requirements
- R1: After reset, all exact entries are disabled, hashing and promiscuous mode are off, and `dec_valid` is low; a unicast address strobed right after reset is rejected with source 0.
- R2: Every cycle with `da_valid` high yields exactly one decision with `dec_valid` high two clock edges later, also for strobes on consecutive cycles; when `dec_valid` is low, `dec_accept`, `dec_src` and `dec_entry` are 0.
- R3: If one or more enabled exact entries hold an address equal to `da_addr`, the frame is accepted with `dec_src` = 1 and `dec_entry` = the lowest such entry index; for any other source `dec_entry` is 0.
- R4: Entry i is loaded through register addresses 0x10+4*i+w, word w = 0, 1, 2. Word 0 holds address byte 1 in bits 15:8 and byte 0 in bits 7:0, word 1 holds bytes 3:2, and word 2 holds bytes 5:4. Byte k is `da_addr[8k+7:8k]`, and byte 0 is the first byte on the wire.
- R5: An entry whose enable bit is clear never matches, whatever it stores; the enable bits are written at register 0x01, with bit i enabling entry i.
- R6: A write to an address word of an entry that is currently enabled is ignored; the entry keeps its old address.
- R7: The hash bin is computed over the 48 address bits, byte 0 first and least significant bit first within a byte. The CRC register starts at 0xFFFFFFFF. At each bit it shifts left, and it is XORed with 0x04C11DB7 when the old bit 31 differs from the data bit. No final inversion is applied. The bin is CRC bits 28:23. Bin bits 5:4 pick table word 0..3 at register 0x04..0x07 (low, mid-low, mid-high, high), and bin bits 3:0 pick the bit within that word. A multicast address (`da_addr[0]` = 1) whose table bit is set is accepted with `dec_src` = 2 while hash enable (bit 1 of control register 0x00) is set.
- R8: The hash table has no effect on unicast addresses, and none while hash enable is clear.
- R9: With promiscuous mode on (bit 0 of control register 0x00), every strobed address is accepted; the source is 3 unless an exact entry (source 1) or the hash (source 2) also hits, in that priority order.
- R10: An address hit by no rule is rejected with `dec_accept` = 0 and `dec_src` = 0; writes to unmapped register addresses change nothing.
- R11: Entry 0 loaded with all ones and enabled accepts the broadcast address with `dec_src` = 1 and `dec_entry` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| da_valid | input | 1 | Destination address strobe, one cycle per frame |
| da_addr | input | 48 | Destination address, byte 0 in bits 7:0 |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 6 | Register address |
| wr_data | input | 16 | Register write data |
| dec_valid | output | 1 | Decision valid |
| dec_accept | output | 1 | 1 = keep frame, 0 = drop |
| dec_src | output | 2 | 0 none, 1 exact entry, 2 hash, 3 promiscuous |
| dec_entry | output | 2 | Index of the exact entry that hit, else 0 |

## Verification
A strobe sampled at one rising edge has its verdict registered two edges later. A register write sampled at an edge is in force from that edge on, so a strobe sees every write issued in its own cycle or earlier and none issued later. The bench mirrors this ordering. At each falling edge it applies the cycle's write to its model, predicts the verdict for the cycle's strobe, and compares the outputs against the prediction made two falling edges earlier. Directed sequences then exercise each rule, and a long random mix of strobes and writes follows, including writes to enabled entries and to unmapped addresses.

// File: rtl/rxaf_pkg.sv
`timescale 1ns/1ps
package rxaf_pkg;
    localparam int ADDR_BITS   = 48;
    localparam int WORD_W      = 16;
    localparam int ENTRY_WORDS = ADDR_BITS / WORD_W;
    localparam int HASH_WORDS  = 4;
    localparam int HASH_BITS   = HASH_WORDS * WORD_W;
    localparam int BIN_W       = $clog2(HASH_BITS);
    localparam int CRC_W       = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam int BIN_HI      = 28;
    localparam int BIN_LO      = BIN_HI - BIN_W + 1;

    // register map
    localparam int REG_CTRL       = 'h00;
    localparam int REG_ENABLE     = 'h01;
    localparam int REG_HASH_BASE  = 'h04;
    localparam int REG_ENTRY_BASE = 'h10;
    localparam int ENTRY_STRIDE   = 4;

    typedef enum logic [1:0] {
        SRC_NONE    = 2'd0,
        SRC_EXACT   = 2'd1,
        SRC_HASH    = 2'd2,
        SRC_PROMISC = 2'd3
    } src_e;
endpackage

// File: rtl/rxaf_crc_bin.sv
`timescale 1ns/1ps
module rxaf_crc_bin
    import rxaf_pkg::*;
(
    input  logic [ADDR_BITS-1:0] addr,
    output logic [BIN_W-1:0]     bin
);
    logic [CRC_W-1:0] crc;
    logic             fb;

    always_comb begin
        crc = '1;
        fb  = 1'b0;
        for (int i = 0; i < ADDR_BITS; i++) begin
            fb  = crc[CRC_W-1] ^ addr[i];
            crc = {crc[CRC_W-2:0], 1'b0};
            if (fb) begin
                crc = crc ^ CRC_POLY;
            end
        end
        bin = crc[BIN_HI:BIN_LO];
    end
endmodule

// File: rtl/rxaf_regs.sv
`timescale 1ns/1ps
module rxaf_regs
    import rxaf_pkg::*;
#(
    parameter int N_ENTRY = 4,
    parameter int REG_AW  = 6
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic                               wr_en,
    input  logic [REG_AW-1:0]                  wr_addr,
    input  logic [WORD_W-1:0]                  wr_data,
    output logic                               promisc,
    output logic                               hash_en,
    output logic [N_ENTRY-1:0]                 ent_en,
    output logic [N_ENTRY-1:0][ADDR_BITS-1:0]  ent_addr,
    output logic [HASH_BITS-1:0]               hash_tab
);
    typedef struct packed {
        logic                              promisc;
        logic                              hash_en;
        logic [N_ENTRY-1:0]                en;
        logic [N_ENTRY-1:0][ADDR_BITS-1:0] ent;
        logic [HASH_BITS-1:0]              tab;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            if (wr_addr == REG_AW'(REG_CTRL)) begin
                cfg_d.promisc = wr_data[0];
                cfg_d.hash_en = wr_data[1];
            end
            if (wr_addr == REG_AW'(REG_ENABLE)) begin
                cfg_d.en = wr_data[N_ENTRY-1:0];
            end
            for (int h = 0; h < HASH_WORDS; h++) begin
                if (wr_addr == REG_AW'(REG_HASH_BASE + h)) begin
                    cfg_d.tab[h*WORD_W +: WORD_W] = wr_data;
                end
            end
            // address words of an enabled entry are write-protected
            for (int i = 0; i < N_ENTRY; i++) begin
                for (int w = 0; w < ENTRY_WORDS; w++) begin
                    if (wr_addr == REG_AW'(REG_ENTRY_BASE + ENTRY_STRIDE*i + w)
                        && !cfg_q.en[i]) begin
                        cfg_d.ent[i][w*WORD_W +: WORD_W] = wr_data;
                    end
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign promisc  = cfg_q.promisc;
    assign hash_en  = cfg_q.hash_en;
    assign ent_en   = cfg_q.en;
    assign ent_addr = cfg_q.ent;
    assign hash_tab = cfg_q.tab;
endmodule

// File: rtl/rxaf_match.sv
`timescale 1ns/1ps
module rxaf_match
    import rxaf_pkg::*;
#(
    parameter int N_ENTRY = 4,
    parameter int EIDX_W  = 2
) (
    input  logic [ADDR_BITS-1:0]              addr,
    input  logic [N_ENTRY-1:0]                ent_en,
    input  logic [N_ENTRY-1:0][ADDR_BITS-1:0] ent_addr,
    output logic                              hit,
    output logic [EIDX_W-1:0]                 idx
);
    logic [N_ENTRY-1:0] eq;

    for (genvar g = 0; g < N_ENTRY; g++) begin : g_cmp
        assign eq[g] = ent_en[g] && (ent_addr[g] == addr);
    end

    always_comb begin
        idx = '0;
        for (int i = N_ENTRY - 1; i >= 0; i--) begin
            if (eq[i]) begin
                idx = EIDX_W'(i);
            end
        end
    end

    assign hit = |eq;
endmodule

// File: rtl/rxaf_top.sv
`timescale 1ns/1ps
module rxaf_top
    import rxaf_pkg::*;
#(
    parameter int N_ENTRY = 4,
    parameter int REG_AW  = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 da_valid,
    input  logic [47:0]          da_addr,
    input  logic                 wr_en,
    input  logic [REG_AW-1:0]    wr_addr,
    input  logic [15:0]          wr_data,
    output logic                 dec_valid,
    output logic                 dec_accept,
    output logic [1:0]           dec_src,
    output logic [(N_ENTRY > 1 ? $clog2(N_ENTRY) : 1)-1:0] dec_entry
);
    localparam int EIDX_W = (N_ENTRY > 1) ? $clog2(N_ENTRY) : 1;

    typedef struct packed {
        logic                 s1_vld;
        logic [ADDR_BITS-1:0] s1_addr;
        logic [BIN_W-1:0]     s1_bin;
        logic                 o_vld;
        logic                 o_acc;
        src_e                 o_src;
        logic [EIDX_W-1:0]    o_ent;
    } pipe_t;

    pipe_t pipe_d, pipe_q;

    logic                              promisc, hash_en;
    logic [N_ENTRY-1:0]                ent_en;
    logic [N_ENTRY-1:0][ADDR_BITS-1:0] ent_addr;
    logic [HASH_BITS-1:0]              hash_tab;
    logic [BIN_W-1:0]                  in_bin;
    logic                              ex_hit;
    logic [EIDX_W-1:0]                 ex_idx;
    logic                              hash_hit;

    rxaf_regs #(.N_ENTRY(N_ENTRY), .REG_AW(REG_AW)) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .promisc  (promisc),
        .hash_en  (hash_en),
        .ent_en   (ent_en),
        .ent_addr (ent_addr),
        .hash_tab (hash_tab)
    );

    rxaf_crc_bin u_crc (
        .addr (da_addr),
        .bin  (in_bin)
    );

    rxaf_match #(.N_ENTRY(N_ENTRY), .EIDX_W(EIDX_W)) u_match (
        .addr     (pipe_q.s1_addr),
        .ent_en   (ent_en),
        .ent_addr (ent_addr),
        .hit      (ex_hit),
        .idx      (ex_idx)
    );

    assign hash_hit = hash_en && pipe_q.s1_addr[0] && hash_tab[pipe_q.s1_bin];

    always_comb begin
        pipe_d = pipe_q;
        // stage 1: capture address and its hash bin
        pipe_d.s1_vld = da_valid;
        if (da_valid) begin
            pipe_d.s1_addr = da_addr;
            pipe_d.s1_bin  = in_bin;
        end
        // stage 2: rule evaluation against live configuration
        pipe_d.o_vld = pipe_q.s1_vld;
        pipe_d.o_ent = '0;
        pipe_d.o_src = SRC_NONE;
        if (pipe_q.s1_vld) begin
            if (ex_hit) begin
                pipe_d.o_src = SRC_EXACT;
                pipe_d.o_ent = ex_idx;
            end else if (hash_hit) begin
                pipe_d.o_src = SRC_HASH;
            end else if (promisc) begin
                pipe_d.o_src = SRC_PROMISC;
            end
        end
        pipe_d.o_acc = (pipe_d.o_src != SRC_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pipe_q <= '0;
        end else begin
            pipe_q <= pipe_d;
        end
    end

    assign dec_valid  = pipe_q.o_vld;
    assign dec_accept = pipe_q.o_acc;
    assign dec_src    = pipe_q.o_src;
    assign dec_entry  = pipe_q.o_ent;
endmodule

// File: rtl/rxaf_chk.sv
`timescale 1ns/1ps
module rxaf_chk #(
    parameter int EIDX_W = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              da_valid,
    input logic              dec_valid,
    input logic              dec_accept,
    input logic [1:0]        dec_src,
    input logic [EIDX_W-1:0] dec_entry
);
    logic [1:0] strobe_sh;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            strobe_sh <= '0;
        end else begin
            strobe_sh <= {strobe_sh[0], da_valid};
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid == strobe_sh[1]);

    p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !dec_valid |-> (!dec_accept && dec_src == 2'd0 && dec_entry == '0));

    p_accept_src_r10: assert property (@(posedge clk) disable iff (!rst_n)
        dec_valid |-> (dec_accept == (dec_src != 2'd0)));

    p_entry_only_exact_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_src != 2'd1) |-> (dec_entry == '0));

    p_single_verdict_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (dec_valid && !strobe_sh[0]) |=> !dec_valid);
endmodule

bind rxaf_top rxaf_chk #(.EIDX_W(EIDX_W)) u_chk (.*);

// File: tb/sim_rxaf_top.sv
`timescale 1ns/1ps
module sim_rxaf_top;
    localparam int N = 4;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        da_valid;
    logic [47:0] da_addr;
    logic        wr_en;
    logic [5:0]  wr_addr;
    logic [15:0] wr_data;
    logic        dec_valid, dec_accept;
    logic [1:0]  dec_src;
    logic [1:0]  dec_entry;

    always #2.5 clk = ~clk;

    rxaf_top #(.N_ENTRY(N), .REG_AW(6)) u0 (
        .clk(clk), .rst_n(rst_n), .da_valid(da_valid), .da_addr(da_addr),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .dec_valid(dec_valid), .dec_accept(dec_accept),
        .dec_src(dec_src), .dec_entry(dec_entry)
    );

    typedef struct { bit v; bit a; int s; int e; string tag; } pred_t;

    pred_t p1, p2;
    bit          m_promisc, m_hash_en;
    bit   [3:0]  m_en;
    logic [47:0] m_ent [4];
    logic [15:0] m_tab [4];
    int    n_cmp = 0, n_fail = 0;
    bit    done = 0, chk_on = 0;
    string cur_tag = "R1";

    function automatic int ref_bin(input logic [47:0] a);
        logic [31:0] c = 32'hFFFF_FFFF;
        for (int b = 0; b < 6; b++) begin
            logic [7:0] by = a[8*b +: 8];
            for (int j = 0; j < 8; j++) begin
                if (c[31] != by[j]) c = (c << 1) ^ 32'h04C1_1DB7;
                else                c = c << 1;
            end
        end
        return int'(c[28:23]);
    endfunction

    function automatic pred_t predict(bit v, logic [47:0] a);
        pred_t r;
        int hit = -1;
        int bin;
        bit hh;
        r.v = v; r.a = 0; r.s = 0; r.e = 0;
        r.tag = (cur_tag == "") ? "R2" : cur_tag;
        if (!v) return r;
        for (int i = 0; i < N; i++)
            if (hit < 0 && m_en[i] && m_ent[i] == a) hit = i;
        bin = ref_bin(a);
        hh  = m_hash_en && a[0] && m_tab[bin / 16][bin % 16];
        if (hit >= 0)      begin r.s = 1; r.e = hit; r.tag = "R3";  end
        else if (hh)       begin r.s = 2; r.tag = "R7"; end
        else if (m_promisc) begin r.s = 3; r.tag = "R9"; end
        else               begin r.s = 0; r.tag = "R10"; end
        r.a = (r.s != 0);
        if (cur_tag != "") r.tag = cur_tag;
        return r;
    endfunction

    function automatic void model_write(int a, logic [15:0] d);
        if (a == 0) begin m_promisc = d[0]; m_hash_en = d[1]; end
        else if (a == 1) m_en = d[3:0];
        else if (a >= 4 && a < 8) m_tab[a-4] = d;
        else if (a >= 16 && a < 32) begin
            int i = (a - 16) / 4;
            int w = (a - 16) % 4;
            if (w < 3 && !m_en[i]) m_ent[i][16*w +: 16] = d;
        end
    endfunction

    task automatic compare(pred_t p);
        n_cmp++;
        if ({dec_valid, dec_accept, dec_src, dec_entry} !==
            {p.v, p.a, 2'(p.s), 2'(p.e)}) begin
            n_fail++;
            $display("FAIL %s: actual valid=%0b accept=%0b src=%0d entry=%0d, expected valid=%0b accept=%0b src=%0d entry=%0d",
                     p.tag, dec_valid, dec_accept, dec_src, dec_entry, p.v, p.a, p.s, p.e);
        end
    endtask

    task automatic step(bit v, logic [47:0] a, bit w, int wa, logic [15:0] wd);
        pred_t pn;
        @(negedge clk);
        if (chk_on) compare(p2);
        da_valid = v; da_addr = a; wr_en = w; wr_addr = 6'(wa); wr_data = wd;
        if (w) model_write(wa, wd);
        pn = predict(v, a);
        p2 = p1;
        p1 = pn;
    endtask

    task automatic idle(int n);
        for (int k = 0; k < n; k++) step(0, 48'h0, 0, 0, 16'h0);
    endtask
    task automatic wr(int a, logic [15:0] d);
        step(0, 48'h0, 1, a, d);
    endtask
    task automatic strobe(logic [47:0] a);
        step(1, a, 0, 0, 16'h0);
    endtask
    task automatic load_entry(int i, logic [47:0] a);
        wr(1, 16'(m_en & ~(4'b1 << i)));
        wr(16 + 4*i, a[15:0]);
        wr(17 + 4*i, a[31:16]);
        wr(18 + 4*i, a[47:32]);
        wr(1, 16'(m_en | (4'b1 << i)));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_cmp++; n_fail++;
            $display("FAIL watchdog: actual run still busy, expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        logic [47:0] addr_a, addr_b, addr_m, addr_m2;
        int bin_m;
        rst_n = 0; da_valid = 0; da_addr = '0; wr_en = 0; wr_addr = '0; wr_data = '0;
        m_promisc = 0; m_hash_en = 0; m_en = '0;
        for (int i = 0; i < 4; i++) begin m_ent[i] = '0; m_tab[i] = '0; end
        p1 = predict(0, '0); p2 = p1;
        idle(3);
        rst_n = 1; chk_on = 1;

        // R1: reset state, unicast rejected
        cur_tag = "R1";
        idle(2);
        strobe(48'h0000_0000_0000);
        strobe(48'h1122_3344_5566);
        idle(3);

        // R4: word layout of an exact entry
        addr_a = 48'h0913_0043_0700;
        cur_tag = "R4";
        load_entry(1, addr_a);
        strobe(addr_a);
        strobe({addr_a[47:16], addr_a[7:0], addr_a[15:8]});
        idle(3);

        // R11: broadcast through entry 0
        cur_tag = "R11";
        load_entry(0, 48'hFFFF_FFFF_FFFF);
        strobe(48'hFFFF_FFFF_FFFF);
        idle(3);

        // R3: lowest matching index wins
        addr_b = 48'h5566_7788_99AA;
        cur_tag = "R3";
        load_entry(3, addr_b);
        load_entry(2, addr_b);
        strobe(addr_b);
        strobe(addr_a);
        idle(3);

        // R6: writes to an enabled entry are ignored
        cur_tag = "R6";
        wr(16 + 4*2, 16'hDEAD);
        strobe(addr_b);
        strobe({addr_b[47:16], 16'hDEAD});
        idle(3);

        // R5: disabled entry never matches
        cur_tag = "R5";
        wr(1, 16'(m_en & ~4'b0010));
        strobe(addr_a);
        idle(3);

        // R7: hash acceptance for one bin
        addr_m = 48'h1234_5E00_0001;
        bin_m  = ref_bin(addr_m);
        addr_m2 = addr_m;
        for (int k = 1; k < 64; k++) begin
            if (ref_bin(addr_m + 48'(2*k)) != bin_m) begin
                addr_m2 = addr_m + 48'(2*k);
                break;
            end
        end
        cur_tag = "R7";
        wr(4 + bin_m / 16, 16'(1 << (bin_m % 16)));
        wr(0, 16'h0002);
        strobe(addr_m);
        strobe(addr_m2);
        idle(2);
        for (int h = 0; h < 4; h++) wr(4 + h, 16'hFFFF);
        strobe(addr_m2);
        strobe(48'hA5A5_0F0F_3301);
        idle(3);

        // R8: unicast ignores hash; hash off ignores table
        cur_tag = "R8";
        strobe(48'hA5A5_0F0F_3300);
        wr(0, 16'h0000);
        strobe(addr_m);
        idle(3);

        // R9: promiscuous accepts all, exact keeps priority
        cur_tag = "R9";
        wr(0, 16'h0001);
        strobe(48'h0102_0304_0506);
        strobe(addr_b);
        strobe(addr_m);
        idle(3);

        // R10: unmapped writes change nothing
        cur_tag = "R10";
        wr(0, 16'h0000);
        wr(16 + 4*1 + 3, 16'h1234);
        wr(2, 16'hFFFF);
        wr(63, 16'hFFFF);
        strobe(48'h0102_0304_0506);
        idle(3);

        // R2: back-to-back strobes
        cur_tag = "R2";
        strobe(addr_b);
        strobe(48'hFFFF_FFFF_FFFF);
        strobe(48'h0102_0304_0506);
        strobe(addr_b);
        idle(3);

        // random mix
        cur_tag = "";
        for (int c = 0; c < 3000; c++) begin
            int sel = $urandom % 8;
            logic [47:0] ra;
            ra = {$urandom, $urandom} & 48'hFFFF_FFFF_FFFF;
            case ($urandom % 4)
                0: ra = m_ent[$urandom % 4];
                1: ra = 48'hFFFF_FFFF_FFFF;
                2: ra[0] = 1'b1;
                default: ra[0] = 1'b0;
            endcase
            if (sel == 0)
                step(1, ra, 1, int'($urandom % 64), 16'($urandom));
            else if (sel < 5)
                step(1, ra, 0, 0, 16'h0);
            else
                step(0, 48'h0, 0, 0, 16'h0);
        end
        idle(4);

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
        $finish;
    end
endmodule